// File: doc/BRIEF.md
# Converted Value Window Comparator

This block watches the stream of converted samples coming out of an analog front end and tests each valid result against a programmable lower bound and upper bound. Software picks one of four conditions: below the lower bound, above the upper bound, inside the window, or outside it. When a qualifying sample meets the chosen condition, the block latches a compare-event flag and pulses an interrupt request for one cycle.

A channel gate limits the test to one selected channel. Setting the all-channels input lets every channel through. The event flag is held by a two-state machine. In `ST_ARMED` no event is pending, and transition T_SET moves to `ST_FLAGGED` on a qualifying hit. `ST_FLAGGED` keeps the flag and is left only by transition T_CLR, which needs a clear request in a cycle with no hit. In every other case the machine stays where it is (T_HOLD).

Top module: `win_cmp`

## Requirements
- R1: After reset, `evt_flag` and `irq` are both 0.
- R2: When `cmp_mode` = 0 (below), a sample is a hit when `res_data < thr_lo`. A sample equal to `thr_lo` is not a hit.
- R3: When `cmp_mode` = 1 (above), a sample is a hit when `res_data > thr_hi`. A sample equal to `thr_hi` is not a hit.
- R4: When `cmp_mode` = 2 (inside), a sample is a hit when `thr_lo <= res_data <= thr_hi`. Both bounds count as inside.
- R5: When `cmp_mode` = 3 (outside), a sample is a hit when `res_data < thr_lo` or `res_data > thr_hi`. Both bounds count as not outside.
- R6: A cycle with `res_valid` = 0 never produces a hit, whatever the data.
- R7: While `all_chan` = 0, only samples whose `res_chan` equals `chan_sel` can hit. While `all_chan` = 1, samples on every channel can hit.
- R8: A hit sets `evt_flag` in the cycle after the hit. The flag then stays at 1 until a clear is accepted.
- R9: An `evt_clear` in a cycle with no hit drops `evt_flag` in the next cycle. If `evt_clear` and a hit arrive in the same cycle, the flag is 1 in the next cycle.
- R10: `irq` is 1 in exactly the cycle after each hit and 0 in the cycle after every cycle with no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Converted sample is valid this cycle |
| res_data | input | DATA_W | Converted sample value (unsigned) |
| res_chan | input | CH_W | Channel the sample came from |
| thr_lo | input | DATA_W | Lower bound |
| thr_hi | input | DATA_W | Upper bound |
| cmp_mode | input | 2 | 0 below, 1 above, 2 inside, 3 outside |
| chan_sel | input | CH_W | Channel watched while `all_chan` is 0 |
| all_chan | input | 1 | Watch every channel |
| evt_clear | input | 1 | Request to clear the event flag |
| evt_flag | output | 1 | Sticky compare event |
| irq | output | 1 | One-cycle pulse per hit |

## Verification
Random samples are drawn in each of the four modes against random bounds. These runs separate the modes from one another, and they expose swapped bounds or swapped comparison directions. Directed samples at each bound and one step past it, including a one-value window where the two bounds are equal, separate inclusive tests from strict ones. Further stimulus covers matching data with the valid input low, samples on channels that are not selected with and without the all-channels input, and a clear issued alone and together with a hit. This stimulus separates the gating, the sticky hold and the priority of a hit over a clear.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
    typedef enum logic [1:0] {
        CMP_BELOW   = 2'd0,
        CMP_ABOVE   = 2'd1,
        CMP_INSIDE  = 2'd2,
        CMP_OUTSIDE = 2'd3
    } cmp_mode_e;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_FLAGGED = 1'b1
    } evt_state_e;
endpackage

// File: rtl/wcmp_match.sv
module wcmp_match
    import wcmp_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  cmp_mode_e         mode,
    output logic              hit
);
    logic under_lo;
    logic over_hi;

    // Strict comparisons; both bounds belong to the window.
    assign under_lo = value < lo;
    assign over_hi  = value > hi;

    always_comb begin
        unique case (mode)
            CMP_BELOW:   hit = under_lo;
            CMP_ABOVE:   hit = over_hi;
            CMP_INSIDE:  hit = !under_lo && !over_hi;
            CMP_OUTSIDE: hit = under_lo || over_hi;
        endcase
    end
endmodule

// File: rtl/wcmp_chan_gate.sv
module wcmp_chan_gate #(
    parameter int CH_W = 3
) (
    input  logic            valid,
    input  logic [CH_W-1:0] chan,
    input  logic [CH_W-1:0] sel,
    input  logic            all,
    input  logic            raw_hit,
    output logic            qual_hit
);
    logic chan_ok;

    assign chan_ok  = all || (chan == sel);
    assign qual_hit = valid && chan_ok && raw_hit;
endmodule

// File: rtl/wcmp_evt_fsm.sv
module wcmp_evt_fsm
    import wcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag,
    output logic irq
);
    evt_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Next state: T_SET, T_CLR, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (hit)         state_d = ST_FLAGGED;
            ST_FLAGGED: if (clr && !hit) state_d = ST_ARMED;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hit;
    end

    assign flag = (state_q == ST_FLAGGED);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r9_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);
endmodule

// File: rtl/win_cmp.sv
module win_cmp
    import wcmp_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   res_chan,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [1:0]        cmp_mode,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic              all_chan,
    input  logic              evt_clear,
    output logic              evt_flag,
    output logic              irq
);
    logic raw_hit;
    logic qual_hit;

    wcmp_match #(.DATA_W(DATA_W)) u_match (
        .value (res_data),
        .lo    (thr_lo),
        .hi    (thr_hi),
        .mode  (cmp_mode_e'(cmp_mode)),
        .hit   (raw_hit)
    );

    wcmp_chan_gate #(.CH_W(CH_W)) u_gate (
        .valid    (res_valid),
        .chan     (res_chan),
        .sel      (chan_sel),
        .all      (all_chan),
        .raw_hit  (raw_hit),
        .qual_hit (qual_hit)
    );

    wcmp_evt_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (qual_hit),
        .clr   (evt_clear),
        .flag  (evt_flag),
        .irq   (irq)
    );

    a_r6_no_valid_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !irq);
    a_r7_filtered_chan: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !all_chan && res_chan != chan_sel) |=> !irq);
    a_r10_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> evt_flag);
endmodule

// File: tb/sim_win_cmp.sv
`timescale 1ns/1ps
module sim_win_cmp;
    localparam int DW = 12;
    localparam int NC = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [CW-1:0] res_chan = '0;
    logic [DW-1:0] thr_lo = '0;
    logic [DW-1:0] thr_hi = '0;
    logic [1:0]    cmp_mode = 2'd0;
    logic [CW-1:0] chan_sel = '0;
    logic          all_chan = 1'b1;
    logic          evt_clear = 1'b0;
    logic          evt_flag;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_flag = 1'b0;
    logic exp_irq  = 1'b0;

    always #4 clk = ~clk;

    win_cmp #(.DATA_W(DW), .NUM_CH(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .thr_lo(thr_lo), .thr_hi(thr_hi), .cmp_mode(cmp_mode),
        .chan_sel(chan_sel), .all_chan(all_chan), .evt_clear(evt_clear),
        .evt_flag(evt_flag), .irq(irq)
    );

    function automatic logic model_hit(input logic v, input logic [DW-1:0] d,
                                       input logic [CW-1:0] ch);
        logic cond;
        case (cmp_mode)
            2'd0:    cond = d < thr_lo;
            2'd1:    cond = d > thr_hi;
            2'd2:    cond = (d >= thr_lo) && (d <= thr_hi);
            default: cond = (d < thr_lo) || (d > thr_hi);
        endcase
        return v && (all_chan || ch == chan_sel) && cond;
    endfunction

    task automatic step(input logic v, input logic [DW-1:0] d,
                        input logic [CW-1:0] ch, input logic clr, input string tag);
        logic h;
        res_valid = v; res_data = d; res_chan = ch; evt_clear = clr;
        h = model_hit(v, d, ch);
        exp_irq  = h;
        exp_flag = h ? 1'b1 : (clr ? 1'b0 : exp_flag);
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (evt_flag !== exp_flag || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b (mode=%0d d=%0d lo=%0d hi=%0d)",
                     tag, evt_flag, irq, exp_flag, exp_irq, cmp_mode, d, thr_lo, thr_hi);
        end
    endtask

    task automatic do_clear();
        step(1'b0, '0, '0, 1'b1, "R9");
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (evt_flag !== 1'b0 || irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: flag=%b irq=%b expected 0 0", evt_flag, irq);
        end

        // R2 below, strict at lower bound
        cmp_mode = 2'd0; thr_lo = 12'd100; thr_hi = 12'd200;
        step(1'b1, 12'd100, 3'd0, 1'b0, "R2");
        step(1'b1, 12'd99,  3'd0, 1'b0, "R2");
        do_clear();
        // R3 above, strict at upper bound
        cmp_mode = 2'd1;
        step(1'b1, 12'd200, 3'd1, 1'b0, "R3");
        step(1'b1, 12'd201, 3'd1, 1'b0, "R3");
        do_clear();
        // R4 inside, single-value window
        cmp_mode = 2'd2; thr_lo = 12'd50; thr_hi = 12'd50;
        step(1'b1, 12'd49, 3'd2, 1'b0, "R4");
        step(1'b1, 12'd51, 3'd2, 1'b0, "R4");
        step(1'b1, 12'd50, 3'd2, 1'b0, "R4");
        do_clear();
        // R5 outside, both bounds not outside
        cmp_mode = 2'd3; thr_lo = 12'd10; thr_hi = 12'd20;
        step(1'b1, 12'd10, 3'd3, 1'b0, "R5");
        step(1'b1, 12'd20, 3'd3, 1'b0, "R5");
        step(1'b1, 12'd9,  3'd3, 1'b0, "R5");
        do_clear();
        step(1'b1, 12'd21, 3'd3, 1'b0, "R5");
        do_clear();
        // R6 valid low with matching data
        step(1'b0, 12'd0, 3'd3, 1'b0, "R6");
        step(1'b0, 12'd4095, 3'd3, 1'b0, "R6");
        // R7 channel filter
        all_chan = 1'b0; chan_sel = 3'd5;
        step(1'b1, 12'd0, 3'd4, 1'b0, "R7");
        step(1'b1, 12'd0, 3'd5, 1'b0, "R7");
        do_clear();
        all_chan = 1'b1;
        step(1'b1, 12'd0, 3'd4, 1'b0, "R7");
        // R8 sticky hold, R10 irq drops
        step(1'b1, 12'd15, 3'd4, 1'b0, "R8");
        step(1'b0, 12'd0,  3'd4, 1'b0, "R10");
        step(1'b0, 12'd0,  3'd4, 1'b0, "R8");
        // R9 clear together with hit: hit wins
        step(1'b1, 12'd0, 3'd4, 1'b1, "R9");
        step(1'b1, 12'd15, 3'd4, 1'b1, "R9");
        step(1'b0, 12'd15, 3'd4, 1'b0, "R9");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [DW-1:0] a, b, d;
            logic [CW-1:0] ch;
            logic v, c;
            string tag;
            if (i % 500 == 0) begin
                cmp_mode = 2'($urandom_range(0, 3));
                a = DW'($urandom); b = DW'($urandom);
                thr_lo = (a < b) ? a : b;
                thr_hi = (a < b) ? b : a;
                all_chan = 1'($urandom);
                chan_sel = CW'($urandom);
            end
            case ($urandom_range(0, 3))
                0: d = thr_lo;
                1: d = thr_hi;
                default: d = DW'($urandom);
            endcase
            ch = CW'($urandom);
            v  = ($urandom_range(0, 7) != 0);
            c  = ($urandom_range(0, 5) == 0);
            case (cmp_mode)
                2'd0: tag = "R2";
                2'd1: tag = "R3";
                2'd2: tag = "R4";
                default: tag = "R5";
            endcase
            step(v, d, ch, c, tag);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule